// File: doc/BRIEF.md
# Branch Next-PC Resolution Unit

This unit takes one fetched 32-bit branch or jump instruction, the address it was fetched from, and the operand values it needs. It works out where execution continues once the delay slot has run. It also reports whether a return address has to be written, to which register, and with what value. When a "likely" branch is taken it raises a flag, so that the pipeline keeps the delay-slot instruction; otherwise the pipeline annuls it.

The operands are the two source register values (64 bits wide, so that bit tests can reach the upper half), a 32-bit floating-point condition register, a 6-bit DSP position field and a DSP-enable input. The unit flags a fetch address that is not word aligned. It also flags a DSP position branch issued while DSP support is off. An instruction that is not a control transfer is reported as such and falls through to the next word. All results are registered and appear one cycle after the input strobe.

Top module: `brnext_unit`

## Requirements
- R1: A taken conditional branch resolves to PC + 4 + (sign-extended instr[15:0] << 2). A conditional branch that is not taken resolves to PC + 8.
- R2: Every linking form writes PC + 8. Register jump-and-link (opcode 0, funct 9) writes it to register instr[15:11]. The REGIMM link forms (rt 16..19) and jal (opcode 3) write it to register 31. REGIMM link forms write the link whether or not the branch is taken.
- R3: Register jumps (opcode 0 with funct 8 or 9) resolve to the low 32 bits of rs.
- R4: REGIMM (opcode 1) decodes instr[20:16]. Codes 0/16 branch if rs < 0 and codes 1/17 branch if rs >= 0, both signed. Codes 2/3/18/19 are the same tests in likely form and raise `likely_taken` only when taken.
- R5: Opcodes 4/5 branch on rs == rt and rs != rt. Opcodes 6/7 branch on signed rs <= 0 and rs > 0, and rt has no effect. Opcodes 0x14..0x17 are the likely forms of these four.
- R6: Opcode 0x11 with instr[25:21] = 8 is a floating-point branch. Index instr[20:18] selects condition bit 23 for index 0, or bit 24+index otherwise. instr[17:16] selects the form: 0 branch-if-clear, 1 branch-if-set, 2 clear-likely, 3 set-likely.
- R7: REGIMM code 0x1C branches when the DSP position is 32 or more. When DSP is disabled, it instead raises `fault_dsp` with next PC 0, no link and no likely flag.
- R8: Opcodes 0x32/0x3A test bit instr[20:16] of rs, and 0x36/0x3E test bit instr[20:16]+32. 0x32/0x36 branch when the bit is 0, and 0x3A/0x3E branch when it is 1.
- R9: j (opcode 2) and jal (opcode 3) resolve to {(PC+4)[31:28], instr[25:0], 2'b00}.
- R10: A PC with a nonzero low two bits raises `fault_misalign`. That result has next PC 0, no link, no likely flag and no other flag, whatever the instruction.
- R11: Any other encoding raises `not_branch` and resolves to PC + 4, with no link.
- R12: `out_valid` rises exactly one cycle after each `in_valid` cycle and is otherwise low. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| rs_val | input | 64 | rs operand value |
| rt_val | input | 64 | rt operand value |
| fcc | input | 32 | Floating-point condition register |
| dsp_pos | input | 6 | DSP position field |
| dsp_en | input | 1 | DSP branch support enabled |
| out_valid | output | 1 | Result valid |
| next_pc | output | 32 | Resolved address after the delay slot |
| link_we | output | 1 | Return address must be written |
| link_idx | output | 5 | Register that receives the link |
| link_val | output | 32 | Return address (PC + 8) |
| likely_taken | output | 1 | Taken likely branch; keep delay slot |
| not_branch | output | 1 | Instruction is not a control transfer |
| fault_misalign | output | 1 | PC not word aligned |
| fault_dsp | output | 1 | DSP branch with DSP disabled |

## Verification
Each result is due in the cycle after the strobe: one register stage sits between the inputs and every output, and `out_valid` drops again one cycle later. The bench drives each stimulus on a falling edge and holds the strobe for one cycle. It reads every output on the next falling edge, after the single capturing rising edge. In a separate case it reads one falling edge later still, to see `out_valid` low. Reset values are read before the first strobe.

// File: rtl/brnext_pkg.sv
package brnext_pkg;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_REGIMM  = 6'h01;
  localparam logic [5:0] OP_J       = 6'h02;
  localparam logic [5:0] OP_JAL     = 6'h03;
  localparam logic [5:0] OP_COP1    = 6'h11;
  localparam logic [5:0] FN_JR      = 6'h08;
  localparam logic [5:0] FN_JALR    = 6'h09;
  localparam logic [4:0] RI_DSPPOS  = 5'h1C;
  localparam logic [4:0] COP1_BC    = 5'h08;

  typedef enum logic [2:0] {
    K_NONE,
    K_COND,
    K_REG,
    K_JUMP,
    K_DSPFAULT
  } kind_e;

  function automatic logic [31:0] branch_target(input logic [31:0] pc,
                                                input logic [15:0] imm);
    return pc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
  endfunction

  function automatic logic [31:0] jump_target(input logic [31:0] pc,
                                              input logic [25:0] tgt);
    logic [31:0] p4;
    p4 = pc + 32'd4;
    return {p4[31:28], tgt, 2'b00};
  endfunction

  function automatic logic [4:0] fcc_pos(input logic [2:0] idx);
    return (idx == 3'd0) ? 5'd23 : 5'(5'd24 + {2'b00, idx});
  endfunction

endpackage

// File: rtl/brnext_decode.sv
module brnext_decode
  import brnext_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter logic [4:0] RA_IDX = 5'd31
) (
  input  logic [5:0]        op,
  input  logic [4:0]        rs_f,
  input  logic [4:0]        rt_f,
  input  logic [4:0]        rd_f,
  input  logic [5:0]        fn,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [31:0]       fcc,
  input  logic [5:0]        dsp_pos,
  input  logic              dsp_en,
  output kind_e             kind,
  output logic              taken,
  output logic              likely,
  output logic              link_we,
  output logic [4:0]        link_idx
);
  logic rs_neg, rs_zero, fcc_bit, test_bit;
  logic [5:0] bit_sel;

  assign rs_neg   = rs_val[DATA_W-1];
  assign rs_zero  = (rs_val == '0);
  assign fcc_bit  = fcc[fcc_pos(rt_f[4:2])];
  assign bit_sel  = {op[2], rt_f};
  assign test_bit = rs_val[bit_sel];

  always_comb begin
    kind     = K_NONE;
    taken    = 1'b0;
    likely   = 1'b0;
    link_we  = 1'b0;
    link_idx = RA_IDX;
    case (op)
      OP_SPECIAL: begin
        if (fn == FN_JR || fn == FN_JALR) kind = K_REG;
        if (fn == FN_JALR) begin
          link_we  = 1'b1;
          link_idx = rd_f;
        end
      end
      OP_REGIMM: begin
        if (rt_f inside {5'd0, 5'd1, 5'd2, 5'd3, 5'd16, 5'd17, 5'd18, 5'd19}) begin
          kind    = K_COND;
          taken   = rt_f[0] ? !rs_neg : rs_neg;
          likely  = rt_f[1] & taken;
          link_we = rt_f[4];
        end else if (rt_f == RI_DSPPOS) begin
          if (dsp_en) begin
            kind  = K_COND;
            taken = (dsp_pos >= 6'd32);
          end else begin
            kind = K_DSPFAULT;
          end
        end
      end
      OP_J: kind = K_JUMP;
      OP_JAL: begin
        kind    = K_JUMP;
        link_we = 1'b1;
      end
      OP_COP1: begin
        if (rs_f == COP1_BC) begin
          kind   = K_COND;
          taken  = rt_f[0] ? fcc_bit : !fcc_bit;
          likely = rt_f[1] & taken;
        end
      end
      default: begin
        if (op inside {6'h04, 6'h05, 6'h06, 6'h07, 6'h14, 6'h15, 6'h16, 6'h17}) begin
          kind = K_COND;
          case (op[1:0])
            2'd0:    taken = (rs_val == rt_val);
            2'd1:    taken = (rs_val != rt_val);
            2'd2:    taken = rs_neg | rs_zero;
            default: taken = !rs_neg & !rs_zero;
          endcase
          likely = op[4] & taken;
        end else if (op inside {6'h32, 6'h36, 6'h3A, 6'h3E}) begin
          kind  = K_COND;
          taken = op[3] ? test_bit : !test_bit;
        end
      end
    endcase
  end
endmodule

// File: rtl/brnext_target.sv
module brnext_target
  import brnext_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [31:0]       pc,
  input  logic [25:0]       instr_lo,
  input  logic [DATA_W-1:0] rs_val,
  input  kind_e             kind,
  input  logic              taken,
  output logic [31:0]       target
);
  always_comb begin
    case (kind)
      K_COND:  target = taken ? branch_target(pc, instr_lo[15:0]) : pc + 32'd8;
      K_REG:   target = rs_val[31:0];
      K_JUMP:  target = jump_target(pc, instr_lo);
      K_NONE:  target = pc + 32'd4;
      default: target = '0;
    endcase
  end
endmodule

// File: rtl/brnext_unit.sv
module brnext_unit
  import brnext_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter logic [4:0] RA_IDX = 5'd31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [31:0]       pc,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [31:0]       fcc,
  input  logic [5:0]        dsp_pos,
  input  logic              dsp_en,
  output logic              out_valid,
  output logic [31:0]       next_pc,
  output logic              link_we,
  output logic [4:0]        link_idx,
  output logic [31:0]       link_val,
  output logic              likely_taken,
  output logic              not_branch,
  output logic              fault_misalign,
  output logic              fault_dsp
);
  kind_e       dec_kind;
  logic        dec_taken, dec_likely, dec_link;
  logic [4:0]  dec_link_idx;
  logic [31:0] tgt_pc;
  logic        pc_misaligned;

  assign pc_misaligned = |pc[1:0];

  brnext_decode #(.DATA_W(DATA_W), .RA_IDX(RA_IDX)) u_dec (
    .op(instr[31:26]), .rs_f(instr[25:21]), .rt_f(instr[20:16]),
    .rd_f(instr[15:11]), .fn(instr[5:0]),
    .rs_val(rs_val), .rt_val(rt_val), .fcc(fcc),
    .dsp_pos(dsp_pos), .dsp_en(dsp_en),
    .kind(dec_kind), .taken(dec_taken), .likely(dec_likely),
    .link_we(dec_link), .link_idx(dec_link_idx)
  );

  brnext_target #(.DATA_W(DATA_W)) u_tgt (
    .pc(pc), .instr_lo(instr[25:0]), .rs_val(rs_val),
    .kind(dec_kind), .taken(dec_taken), .target(tgt_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      next_pc        <= '0;
      link_we        <= 1'b0;
      link_idx       <= '0;
      link_val       <= '0;
      likely_taken   <= 1'b0;
      not_branch     <= 1'b0;
      fault_misalign <= 1'b0;
      fault_dsp      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        next_pc        <= pc_misaligned ? 32'd0 : tgt_pc;
        link_we        <= !pc_misaligned && dec_link;
        link_idx       <= dec_link_idx;
        link_val       <= pc + 32'd8;
        likely_taken   <= !pc_misaligned && dec_likely;
        not_branch     <= !pc_misaligned && (dec_kind == K_NONE);
        fault_misalign <= pc_misaligned;
        fault_dsp      <= !pc_misaligned && (dec_kind == K_DSPFAULT);
      end
    end
  end
endmodule

// File: rtl/brnext_unit_chk.sv
module brnext_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] pc,
  input logic        out_valid,
  input logic [31:0] next_pc,
  input logic        link_we,
  input logic [31:0] link_val,
  input logic        likely_taken,
  input logic        not_branch,
  input logic        fault_misalign,
  input logic        fault_dsp
);
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r12_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!link_we || link_val == $past(pc) + 32'd8));
  a_r10_misalign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fault_misalign) |-> (!link_we && !likely_taken && next_pc == 32'd0));
  a_r11_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!not_branch || next_pc == $past(pc) + 32'd4));
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({fault_misalign, fault_dsp, not_branch}));
endmodule

bind brnext_unit brnext_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc(pc),
  .out_valid(out_valid), .next_pc(next_pc), .link_we(link_we),
  .link_val(link_val), .likely_taken(likely_taken), .not_branch(not_branch),
  .fault_misalign(fault_misalign), .fault_dsp(fault_dsp)
);

// File: tb/brnext_unit_tb.sv
module brnext_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0, pc = '0, fcc = '0;
  logic [63:0] rs_val = '0, rt_val = '0;
  logic [5:0]  dsp_pos = '0;
  logic        dsp_en = 1'b1;
  logic        out_valid, link_we, likely_taken, not_branch, fault_misalign, fault_dsp;
  logic [31:0] next_pc, link_val;
  logic [4:0]  link_idx;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  brnext_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
    .rs_val(rs_val), .rt_val(rt_val), .fcc(fcc), .dsp_pos(dsp_pos), .dsp_en(dsp_en),
    .out_valid(out_valid), .next_pc(next_pc), .link_we(link_we), .link_idx(link_idx),
    .link_val(link_val), .likely_taken(likely_taken), .not_branch(not_branch),
    .fault_misalign(fault_misalign), .fault_dsp(fault_dsp)
  );

  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  function automatic logic [31:0] offs(input logic [31:0] p, input int words);
    return p + 32'd4 + 32'(words * 4);
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] p, input logic [63:0] a,
                       input logic [63:0] b);
    @(negedge clk);
    instr = i; pc = p; rs_val = a; rt_val = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic [31:0] epc, input bit elikely,
                            input bit elink, input int eidx);
    chk(req, "out_valid", 64'(out_valid), 64'd1);
    chk(req, "next_pc", 64'(next_pc), 64'(epc));
    chk(req, "likely_taken", 64'(likely_taken), 64'(elikely));
    chk(req, "link_we", 64'(link_we), 64'(elink));
    if (elink) begin
      chk(req, "link_idx", 64'(link_idx), 64'(eidx));
      chk(req, "link_val", 64'(link_val), 64'(pc + 32'd8));
    end
    chk(req, "flags", 64'({not_branch, fault_misalign, fault_dsp}), 64'd0);
  endtask

  task automatic t_reset();
    chk("R12", "reset outputs", 64'({out_valid, link_we, likely_taken, not_branch,
        fault_misalign, fault_dsp}), 64'd0);
    chk("R12", "reset next_pc", 64'(next_pc), 64'd0);
  endtask

  task automatic t_compare();
    apply(enc_i(4, 3, 4, 16), 32'h0000_1000, 64'h55, 64'h55);
    expect_res("R1 R5 beq taken", offs(32'h1000, 16), 0, 0, 0);
    apply(enc_i(5, 3, 4, 16), 32'h0000_1000, 64'h55, 64'h55);
    expect_res("R1 R5 bne not taken", 32'h1008, 0, 0, 0);
    apply(enc_i(6'h14, 3, 4, -3), 32'h0000_2000, 64'h7, 64'h7);
    expect_res("R5 beql likely", offs(32'h2000, -3), 1, 0, 0);
    apply(enc_i(6, 3, 9, 8), 32'h0000_3000, 64'h0, 64'h1234);
    expect_res("R5 blez zero rt ignored", offs(32'h3000, 8), 0, 0, 0);
    apply(enc_i(7, 3, 0, 8), 32'h0000_3000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    expect_res("R5 bgtz negative", 32'h3008, 0, 0, 0);
    apply(enc_i(6'h17, 3, 0, 2), 32'h0000_3000, 64'h1, 64'h0);
    expect_res("R5 bgtzl taken", offs(32'h3000, 2), 1, 0, 0);
  endtask

  task automatic t_regimm();
    apply(enc_i(1, 2, 0, -8), 32'h0000_4000, 64'h8000_0000_0000_0000, 0);
    expect_res("R4 bltz taken", offs(32'h4000, -8), 0, 0, 0);
    apply(enc_i(1, 2, 17, 4), 32'h0000_4000, 64'hFFFF_FFFF_FFFF_FFF0, 0);
    expect_res("R2 R4 bgezal not taken links", 32'h4008, 0, 1, 31);
    apply(enc_i(1, 2, 18, 4), 32'h0000_4000, 64'hFFFF_FFFF_FFFF_FFF0, 0);
    expect_res("R4 bltzall likely", offs(32'h4000, 4), 1, 1, 31);
    apply(enc_i(1, 2, 3, 4), 32'h0000_4000, 64'hFFFF_FFFF_FFFF_FFF0, 0);
    expect_res("R4 bgezl not taken", 32'h4008, 0, 0, 0);
  endtask

  task automatic t_jumps();
    apply({6'd0, 5'd6, 10'd0, 5'd0, 6'h08}, 32'h0000_5000, 64'hDEAD_0000_0000_8000, 0);
    expect_res("R3 jr", 32'h0000_8000, 0, 0, 0);
    apply({6'd0, 5'd6, 5'd0, 5'd7, 5'd0, 6'h09}, 32'h0000_5000, 64'h0000_0000_0001_2340, 0);
    expect_res("R2 R3 jalr rd", 32'h0001_2340, 0, 1, 7);
    apply({6'd2, 26'h0123456}, 32'h9000_0010, 0, 0);
    expect_res("R9 j", {4'h9, 26'h0123456, 2'b00}, 0, 0, 0);
    apply({6'd3, 26'h3FFFFFF}, 32'hEFFF_FFFC, 0, 0);
    expect_res("R9 R2 jal region", 32'hFFFF_FFFC, 0, 1, 31);
  endtask

  task automatic t_fp();
    fcc = 32'h0080_0000;
    apply(enc_i(6'h11, 8, 1, 5), 32'h0000_6000, 0, 0);
    expect_res("R6 bc1t idx0 bit23", offs(32'h6000, 5), 0, 0, 0);
    apply(enc_i(6'h11, 8, 14, 5), 32'h0000_6000, 0, 0);
    expect_res("R6 bc1fl idx3 likely", offs(32'h6000, 5), 1, 0, 0);
    fcc = 32'h0800_0000;
    apply(enc_i(6'h11, 8, 12, 5), 32'h0000_6000, 0, 0);
    expect_res("R6 bc1f idx3 bit27 set", 32'h6008, 0, 0, 0);
    fcc = '0;
  endtask

  task automatic t_dsp();
    dsp_pos = 6'd32;
    apply(enc_i(1, 0, 28, 6), 32'h0000_7000, 0, 0);
    expect_res("R7 pos 32 taken", offs(32'h7000, 6), 0, 0, 0);
    dsp_pos = 6'd31;
    apply(enc_i(1, 0, 28, 6), 32'h0000_7000, 0, 0);
    expect_res("R7 pos 31 not taken", 32'h7008, 0, 0, 0);
    dsp_en = 1'b0; dsp_pos = 6'd40;
    apply(enc_i(1, 0, 28, 6), 32'h0000_7000, 0, 0);
    chk("R7", "fault_dsp", 64'(fault_dsp), 64'd1);
    chk("R7", "fault next_pc", 64'(next_pc), 64'd0);
    chk("R7", "fault link/likely", 64'({link_we, likely_taken, not_branch}), 64'd0);
    dsp_en = 1'b1;
  endtask

  task automatic t_bittest();
    apply(enc_i(6'h3A, 2, 5, 9), 32'h0000_8000, 64'h20, 0);
    expect_res("R8 bit1 set", offs(32'h8000, 9), 0, 0, 0);
    apply(enc_i(6'h32, 2, 5, 9), 32'h0000_8000, 64'h20, 0);
    expect_res("R8 bit0 set not taken", 32'h8008, 0, 0, 0);
    apply(enc_i(6'h36, 2, 3, 9), 32'h0000_8000, 64'h0000_0000_FFFF_FFFF, 0);
    expect_res("R8 bit0 upper clear", offs(32'h8000, 9), 0, 0, 0);
    apply(enc_i(6'h3E, 2, 3, 9), 32'h0000_8000, 64'h0000_0000_FFFF_FFFF, 0);
    expect_res("R8 bit1 upper clear", 32'h8008, 0, 0, 0);
  endtask

  task automatic t_misalign();
    apply({6'd3, 26'h1234}, 32'h0000_9002, 0, 0);
    chk("R10", "fault_misalign", 64'(fault_misalign), 64'd1);
    chk("R10", "next_pc", 64'(next_pc), 64'd0);
    chk("R10", "others", 64'({link_we, likely_taken, not_branch, fault_dsp}), 64'd0);
  endtask

  task automatic t_other();
    apply(enc_i(9, 1, 2, 3), 32'h0000_A000, 0, 0);
    chk("R11", "not_branch", 64'(not_branch), 64'd1);
    chk("R11", "next_pc", 64'(next_pc), 64'h0000_A004);
    chk("R11", "link_we", 64'(link_we), 64'd0);
    apply({6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20}, 32'h0000_B000, 0, 0);
    chk("R11", "special add", 64'({not_branch, next_pc}), {31'd0, 1'b1, 32'h0000_B004});
    @(negedge clk);
    chk("R12", "out_valid low after pulse", 64'(out_valid), 64'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_compare();
    t_regimm();
    t_jumps();
    t_fp();
    t_dsp();
    t_bittest();
    t_misalign();
    t_other();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule